// File: doc/BRIEF.md
# Banked GPIO Interrupt Controller

This block is a memory-mapped general-purpose I/O unit with several banks of sixteen pins. For every pin it stores a direction, an output value and an alternate-function select, and it reports the live pin state. Each pin can also raise an interrupt: a rising edge, a falling edge, an active-high level or an active-low level, picked per pin. Pending pin interrupts are held in a per-bank status register until software clears them.

A small control region adds one summary register. It has one bit per bank that is set while that bank has anything pending, followed by bits for auxiliary non-GPIO sources. A single registered interrupt line goes to the host. The host side is a plain 16-bit register bus with a write strobe and a combinational read path. Software gets both-edge detection by flipping a pin's polarity bit after each event it handles.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every bank's interrupt mask reads 0xFFFF. Every other bank register, the summary and the auxiliary control register read 0, and `host_irq` is low.
- R2: The address is {region[6:4], offset[3:0]}. Regions 0 to 3 are banks, and bank b owns pins 16b to 16b+15. Offsets 4 (direction, 1 = output), 5 (output value) and 7 (alternate select) are read/write. They appear on `gpio_oe`, `gpio_out` and `alt_sel` from the cycle after the write.
- R3: Offset 6 (pin state) returns the output value for pins whose direction bit is 1. For other pins it returns the input after two synchronizer stages.
- R4: When a pin's trigger-type bit (offset 1) is 1 and its edge-polarity bit (offset 2) is 1, a rising edge on the pin sets its pending bit (offset 8).
- R5: When trigger type is 1 and edge polarity is 0, a falling edge sets the pending bit and a rising edge does not.
- R6: When trigger type is 0, the level-polarity bit (offset 3) selects active-high (1) or active-low (0). While the level stays active, the pending bit is set again every cycle, even right after software clears it.
- R7: A mask bit (offset 0) of 1 stops that pin from setting its pending bit.
- R8: A write to offset 8 keeps only the pending bits where the written data is 1. Writing zero clears the whole bank.
- R9: The summary register (region 4, offset 0) has bank b's any-pending flag at bit b. At bit 4+k it has auxiliary source k ANDed with enable bit k of the auxiliary control register (region 4, offset 1). Bits 15:10 read 0.
- R10: `host_irq` is a register. It goes high one cycle after the OR of the summary bits is high while the global enable, bit 15 of the auxiliary control register, is 1. Otherwise it goes low.
- R11: A write to a pin's edge-polarity bit takes effect for the next transition that follows the write. This allows both-edge detection by toggling the bit.
- R12: Writes to the pin-state offset and to the summary register change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 7 | Region and register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| gpio_in | input | 64 | Pin input levels |
| gpio_out | output | 64 | Output values |
| gpio_oe | output | 64 | Output enables (direction) |
| alt_sel | output | 64 | Alternate-function selects |
| aux_src | input | 6 | Auxiliary interrupt sources |
| host_irq | output | 1 | Registered interrupt to the host |

## Verification
The tests drive pins in four detection modes and compare the expected pending words. Pins in the same bank are set to opposite polarities, so a polarity mix-up shows up as a wrong bit in the word and not as a missing interrupt. Level sources are cleared while their level is still active, which separates level re-assertion from edge latching. Masked pins are held at active levels, so any leak through the mask sets a pending bit. The edge-polarity toggle is exercised rise-then-fall on one pin. Auxiliary sources are driven with one enabled source and one disabled source, with the global enable switched both ways, which separates the summary bits from the gating of the host line.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int BUS_W = 16;
  localparam int OFS_W = 4;

  // bank register offsets
  localparam logic [OFS_W-1:0] OFS_MASK = 4'd0;
  localparam logic [OFS_W-1:0] OFS_TRIG = 4'd1;
  localparam logic [OFS_W-1:0] OFS_EPOL = 4'd2;
  localparam logic [OFS_W-1:0] OFS_LPOL = 4'd3;
  localparam logic [OFS_W-1:0] OFS_DIR  = 4'd4;
  localparam logic [OFS_W-1:0] OFS_OUT  = 4'd5;
  localparam logic [OFS_W-1:0] OFS_PIN  = 4'd6;
  localparam logic [OFS_W-1:0] OFS_ALT  = 4'd7;
  localparam logic [OFS_W-1:0] OFS_PEND = 4'd8;

  // control region offsets
  localparam logic [OFS_W-1:0] OFS_SUMMARY = 4'd0;
  localparam logic [OFS_W-1:0] OFS_AUXCTL  = 4'd1;
  localparam int GLOBAL_EN_BIT = 15;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] reg_sel,
  input  logic [PINS-1:0]  wdata,
  input  logic [PINS-1:0]  pin_in,
  output logic [PINS-1:0]  rdata,
  output logic [PINS-1:0]  pin_oe,
  output logic [PINS-1:0]  pin_out,
  output logic [PINS-1:0]  pin_alt,
  output logic             pend_any
);
  logic [PINS-1:0] mask_q, mask_n;
  logic [PINS-1:0] trig_q, trig_n;
  logic [PINS-1:0] epol_q, epol_n;
  logic [PINS-1:0] lpol_q, lpol_n;
  logic [PINS-1:0] dir_q,  dir_n;
  logic [PINS-1:0] out_q,  out_n;
  logic [PINS-1:0] alt_q,  alt_n;
  logic [PINS-1:0] pend_q, pend_n;
  logic [PINS-1:0] prev_q;
  logic [PINS-1:0] pin_s;
  logic [PINS-1:0] edge_hit, level_hit, hit;

  gpio_irq_sync #(.W(PINS)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_s)
  );

  // detection on synchronized pins against the previous synchronized value
  always_comb begin
    edge_hit  = trig_q & ((epol_q & pin_s & ~prev_q) | (~epol_q & ~pin_s & prev_q));
    level_hit = ~trig_q & ~(pin_s ^ lpol_q);
    hit       = (edge_hit | level_hit) & ~mask_q;
  end

  always_comb begin
    mask_n = (wr_en && reg_sel == OFS_MASK) ? wdata : mask_q;
    trig_n = (wr_en && reg_sel == OFS_TRIG) ? wdata : trig_q;
    epol_n = (wr_en && reg_sel == OFS_EPOL) ? wdata : epol_q;
    lpol_n = (wr_en && reg_sel == OFS_LPOL) ? wdata : lpol_q;
    dir_n  = (wr_en && reg_sel == OFS_DIR)  ? wdata : dir_q;
    out_n  = (wr_en && reg_sel == OFS_OUT)  ? wdata : out_q;
    alt_n  = (wr_en && reg_sel == OFS_ALT)  ? wdata : alt_q;
    // new detections win over a clear in the same cycle
    pend_n = ((wr_en && reg_sel == OFS_PEND) ? (pend_q & wdata) : pend_q) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      trig_q <= '0;
      epol_q <= '0;
      lpol_q <= '0;
      dir_q  <= '0;
      out_q  <= '0;
      alt_q  <= '0;
      pend_q <= '0;
      prev_q <= '0;
    end else begin
      mask_q <= mask_n;
      trig_q <= trig_n;
      epol_q <= epol_n;
      lpol_q <= lpol_n;
      dir_q  <= dir_n;
      out_q  <= out_n;
      alt_q  <= alt_n;
      pend_q <= pend_n;
      prev_q <= pin_s;
    end
  end

  always_comb begin
    unique case (reg_sel)
      OFS_MASK: rdata = mask_q;
      OFS_TRIG: rdata = trig_q;
      OFS_EPOL: rdata = epol_q;
      OFS_LPOL: rdata = lpol_q;
      OFS_DIR:  rdata = dir_q;
      OFS_OUT:  rdata = out_q;
      OFS_PIN:  rdata = (dir_q & out_q) | (~dir_q & pin_s);
      OFS_ALT:  rdata = alt_q;
      OFS_PEND: rdata = pend_q;
      default:  rdata = '0;
    endcase
  end

  assign pin_oe   = dir_q;
  assign pin_out  = out_q;
  assign pin_alt  = alt_q;
  assign pend_any = |pend_q;
endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int NUM_AUX   = 6,
  localparam int SUM_W    = NUM_BANKS + NUM_AUX
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [BUS_W-1:0]     wdata,
  input  logic [NUM_BANKS-1:0] bank_pend,
  input  logic [NUM_AUX-1:0]   aux_src,
  output logic [SUM_W-1:0]     summary,
  output logic [BUS_W-1:0]     ctl_rd,
  output logic                 glob_en,
  output logic                 host_irq
);
  logic [NUM_AUX-1:0] aux_en_q, aux_en_n;
  logic               glob_q, glob_n;
  logic               irq_q, irq_n;

  always_comb begin
    aux_en_n = wr_en ? wdata[NUM_AUX-1:0] : aux_en_q;
    glob_n   = wr_en ? wdata[GLOBAL_EN_BIT] : glob_q;
    summary  = {aux_src & aux_en_q, bank_pend};
    irq_n    = glob_q & (|summary);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_en_q <= '0;
      glob_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      aux_en_q <= aux_en_n;
      glob_q   <= glob_n;
      irq_q    <= irq_n;
    end
  end

  always_comb begin
    ctl_rd                = '0;
    ctl_rd[NUM_AUX-1:0]   = aux_en_q;
    ctl_rd[GLOBAL_EN_BIT] = glob_q;
  end

  assign glob_en  = glob_q;
  assign host_irq = irq_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int NUM_AUX   = 6,
  localparam int PINS     = BUS_W,
  localparam int NPINS    = NUM_BANKS * PINS,
  localparam int REGION_W = $clog2(NUM_BANKS + 1),
  localparam int ADDR_W   = REGION_W + OFS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic [NPINS-1:0]   gpio_in,
  output logic [NPINS-1:0]   gpio_out,
  output logic [NPINS-1:0]   gpio_oe,
  output logic [NPINS-1:0]   alt_sel,
  input  logic [NUM_AUX-1:0] aux_src,
  output logic               host_irq
);
  localparam int SUM_W  = NUM_BANKS + NUM_AUX;
  localparam int BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam logic [REGION_W-1:0] CTL_REGION = REGION_W'(NUM_BANKS);

  logic [REGION_W-1:0]  region;
  logic [OFS_W-1:0]     ofs;
  logic [BIDX_W-1:0]    bank_idx;
  logic                 in_bank;
  logic [BUS_W-1:0]     bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_pend;
  logic [SUM_W-1:0]     summary_w;
  logic [BUS_W-1:0]     ctl_rd;
  logic                 glob_en_w;
  logic                 ctl_we;

  assign region   = bus_addr[ADDR_W-1:OFS_W];
  assign ofs      = bus_addr[OFS_W-1:0];
  assign bank_idx = region[BIDX_W-1:0];
  assign in_bank  = region < CTL_REGION;
  assign ctl_we   = bus_wr && region == CTL_REGION && ofs == OFS_AUXCTL;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_we;
    assign bank_we = bus_wr && region == REGION_W'(b);

    gpio_irq_bank #(.PINS(PINS)) i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bank_we),
      .reg_sel  (ofs),
      .wdata    (bus_wdata),
      .pin_in   (gpio_in[b*PINS +: PINS]),
      .rdata    (bank_rd[b]),
      .pin_oe   (gpio_oe[b*PINS +: PINS]),
      .pin_out  (gpio_out[b*PINS +: PINS]),
      .pin_alt  (alt_sel[b*PINS +: PINS]),
      .pend_any (bank_pend[b])
    );
  end

  gpio_irq_summary #(.NUM_BANKS(NUM_BANKS), .NUM_AUX(NUM_AUX)) i_summary (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctl_we),
    .wdata     (bus_wdata),
    .bank_pend (bank_pend),
    .aux_src   (aux_src),
    .summary   (summary_w),
    .ctl_rd    (ctl_rd),
    .glob_en   (glob_en_w),
    .host_irq  (host_irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (in_bank) begin
      bus_rdata = bank_rd[bank_idx];
    end else if (region == CTL_REGION) begin
      if (ofs == OFS_SUMMARY) bus_rdata[SUM_W-1:0] = summary_w;
      else if (ofs == OFS_AUXCTL) bus_rdata = ctl_rd;
    end
  end
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int NPINS  = 64,
  parameter int SUM_W  = 10,
  parameter int REGION_W = 3,
  parameter int NUM_BANKS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [NPINS-1:0]  gpio_oe,
  input logic [NPINS-1:0]  gpio_out,
  input logic [SUM_W-1:0]  summary,
  input logic              glob_en,
  input logic              host_irq
);
  localparam logic [ADDR_W-1:0] DIR0_ADDR = {REGION_W'(0), OFS_DIR};
  localparam logic [ADDR_W-1:0] SUM_ADDR  = {REGION_W'(NUM_BANKS), OFS_SUMMARY};

  AST_OE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == DIR0_ADDR) |=> (gpio_oe[BUS_W-1:0] == $past(bus_wdata))); // R2

  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(gpio_oe)); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(gpio_out)); // R2

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> $past(glob_en)); // R10

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(|summary) |=> !host_irq); // R10

  AST_SUM_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == SUM_ADDR) |-> (bus_rdata[BUS_W-1:SUM_W] == '0)); // R9
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(
  .ADDR_W(ADDR_W), .NPINS(NPINS), .SUM_W(SUM_W), .REGION_W(REGION_W), .NUM_BANKS(NUM_BANKS)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .gpio_oe   (gpio_oe),
  .gpio_out  (gpio_out),
  .summary   (summary_w),
  .glob_en   (glob_en_w),
  .host_irq  (host_irq)
);

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [6:0]  bus_addr, wr_addr, mon_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [63:0] gpio_in, gpio_out, gpio_oe, alt_sel;
  logic [5:0]  aux_src;
  logic        host_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // kind: 0 bus read, 1 host_irq, 2 gpio_oe bank1, 3 gpio_out bank1, 4 alt_sel bank2
  typedef struct {
    int          kind;
    logic [6:0]  addr;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  assign bus_addr = bus_wr ? wr_addr : mon_addr;

  gpio_irq_ctrl i_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_in(gpio_in),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .alt_sel(alt_sel),
    .aux_src(aux_src), .host_irq(host_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [6:0] ba(int bank, int ofs);
    return {3'(bank), 4'(ofs)};
  endfunction

  // monitor: pops expected items and compares against the design
  initial begin
    mon_addr = '0;
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = sb.pop_front();
        mon_addr = it.addr;
        #1;
        case (it.kind)
          1:       act = {15'd0, host_irq};
          2:       act = gpio_oe[31:16];
          3:       act = gpio_out[31:16];
          4:       act = alt_sel[47:32];
          default: act = bus_rdata;
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expect_item(int kind, logic [6:0] addr, logic [15:0] exp, string tag);
    item_t it;
    it.kind = kind; it.addr = addr; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    drain();
  endtask

  task automatic rd(int bank, int ofs, logic [15:0] exp, string tag);
    expect_item(0, ba(bank, ofs), exp, tag);
  endtask

  task automatic wr(int bank, int ofs, logic [15:0] data);
    @(negedge clk);
    wr_addr = ba(bank, ofs);
    bus_wdata = data;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(int idx, logic v);
    @(negedge clk);
    gpio_in[idx] = v;
    cyc(4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; wr_addr = '0; bus_wdata = '0;
    gpio_in = '0; aux_src = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R1 reset state
    rd(0, 0, 16'hFFFF, "R1 mask bank0");
    rd(3, 0, 16'hFFFF, "R1 mask bank3");
    rd(0, 4, 16'h0000, "R1 dir bank0");
    rd(2, 8, 16'h0000, "R1 pend bank2");
    rd(4, 0, 16'h0000, "R1 summary");
    expect_item(1, '0, 16'h0000, "R1 host_irq");

    // R2 storage and drive
    wr(1, 4, 16'h00F0);
    wr(1, 5, 16'h00A0);
    wr(2, 7, 16'h1234);
    rd(1, 4, 16'h00F0, "R2 dir readback");
    expect_item(2, '0, 16'h00F0, "R2 gpio_oe");
    expect_item(3, '0, 16'h00A0, "R2 gpio_out");
    expect_item(4, '0, 16'h1234, "R2 alt_sel");

    // R3 pin state mix
    gpio_in[31:16] = 16'h5555;
    cyc(4);
    rd(1, 6, 16'h55A5, "R3 pin state");

    // R12 writes to read-only addresses
    wr(1, 6, 16'hFFFF);
    rd(1, 6, 16'h55A5, "R12 pin state unchanged");

    // bank0: pins 0,1 rising, pins 2,3 falling, rest level-low masked
    wr(0, 1, 16'h000F);
    wr(0, 2, 16'h0003);
    wr(0, 0, 16'hFFF0);
    cyc(2);
    rd(0, 8, 16'h0000, "R7 masked active-low pins stay clear");
    set_pin(0, 1'b1);
    rd(0, 8, 16'h0001, "R4 rising edge");
    set_pin(2, 1'b1);
    rd(0, 8, 16'h0001, "R5 rising ignored in falling mode");
    set_pin(2, 1'b0);
    rd(0, 8, 16'h0005, "R5 falling edge");
    rd(4, 0, 16'h0001, "R9 bank0 summary bit");
    expect_item(1, '0, 16'h0000, "R10 irq gated off");
    wr(4, 1, 16'h8000);
    cyc(2);
    expect_item(1, '0, 16'h0001, "R10 irq enabled");

    // R8 selective and full clear
    wr(0, 8, 16'h0004);
    rd(0, 8, 16'h0004, "R8 keep bit 2");
    wr(4, 0, 16'h0000);
    rd(4, 0, 16'h0001, "R12 summary write ignored");
    wr(0, 8, 16'h0000);
    rd(0, 8, 16'h0000, "R8 write zero clears");
    cyc(2);
    expect_item(1, '0, 16'h0000, "R10 irq drops");

    // R6 level-low on pin 5 re-asserts after clear
    wr(0, 0, 16'hFFD0);
    cyc(1);
    rd(0, 8, 16'h0020, "R6 active-low level");
    wr(0, 8, 16'h0000);
    rd(0, 8, 16'h0020, "R6 level re-asserts");
    set_pin(5, 1'b1);
    wr(0, 8, 16'h0000);
    rd(0, 8, 16'h0000, "R6 inactive level clears");

    // R6 active-high on bank3 pin0, R7 pin1 masked while high
    wr(3, 3, 16'h0003);
    wr(3, 0, 16'hFFFE);
    gpio_in[49:48] = 2'b11;
    cyc(4);
    rd(3, 8, 16'h0001, "R6 active-high / R7 masked pin1");
    rd(4, 0, 16'h0008, "R9 bank3 summary bit");
    set_pin(48, 1'b0);
    wr(3, 8, 16'h0000);
    rd(3, 8, 16'h0000, "R6 bank3 cleared");

    // R11 polarity toggle for both-edge use on pin 1
    set_pin(1, 1'b1);
    rd(0, 8, 16'h0002, "R11 rising caught");
    wr(0, 8, 16'h0000);
    wr(0, 2, 16'h0001);
    set_pin(1, 1'b0);
    rd(0, 8, 16'h0002, "R11 falling caught after toggle");
    wr(0, 8, 16'h0000);
    rd(4, 0, 16'h0000, "R9 summary empty");

    // R9/R10 auxiliary sources
    aux_src = 6'b000101;
    wr(4, 1, 16'h8001);
    cyc(1);
    rd(4, 0, 16'h0010, "R9 aux enabled only");
    expect_item(1, '0, 16'h0001, "R10 irq from aux");
    wr(4, 1, 16'h0001);
    cyc(1);
    expect_item(1, '0, 16'h0000, "R10 global off");
    rd(4, 1, 16'h0001, "R10 control readback");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule